// File: doc/BRIEF.md
# Capture Reload Up/Down Timer

This block is a 16-bit timer/counter with a companion 16-bit capture/reload register. A tick generator divides the clock into machine cycles of 12 clocks, and all counting happens on those ticks. In timer function the count advances once per machine cycle. In counter function the count advances on a falling edge of the count pin. Edges on both pins are found by sampling each pin once per machine cycle.

Three modes are chosen by two control inputs. Capture mode is a free-running counter that can snapshot its value into the capture/reload register when the external pin falls. Up-only reload mode restarts from the reload value on wrap, and the external pin can also force that restart. Up/down reload mode takes its direction from the level of the external pin. In this mode a downward pass through the reload value wraps to 0xFFFF, and the external flag acts as a toggling seventeenth bit. A two-state run machine gates all counting and event handling. Software-style writes to the count and the reload register, and the flag clears, are plain strobes.

Top module: `cap_tmr`

The run machine has two states. ST_STOP is the reset state and holds everything frozen. ST_RUN lets ticks act. The transition *start* goes from ST_STOP to ST_RUN on the clock edge where `run` is sampled high. The transition *halt* goes from ST_RUN to ST_STOP on the edge where `run` is sampled low. Each transition therefore takes effect one clock after `run` changes.

## Requirements
- R1: In timer function (`ctr_sel`=0) the count rises by exactly one per machine cycle of 12 clocks and is steady between machine cycles.
- R2: In counter function (`ctr_sel`=1) the count rises by one on the machine cycle where `t2_pin` is sampled low after being sampled high on the previous machine cycle. A pin level that no tick samples is not counted, and a level held high is counted only once, when it falls.
- R3: In capture mode (`cap_sel`=1) the count wraps from 0xFFFF to 0x0000 and that wrap sets `ovf_flag`.
- R4: In capture mode with `ext_en`=1, a sampled falling edge of `t2ex_pin` copies the count held before that tick's increment into `cap_val` and sets `ext_flag`. With `ext_en`=0 the edge changes neither.
- R5: In reload mode counting up (`cap_sel`=0), the increment from 0xFFFF loads `cap_val` into the count and sets `ovf_flag`. Reload mode never alters `cap_val` except through a write.
- R6: In up-only reload mode (`cap_sel`=0, `dn_en`=0) with `ext_en`=1, a sampled falling edge of `t2ex_pin` loads `cap_val` into the count and sets `ext_flag`, without setting `ovf_flag`.
- R7: In up/down mode (`cap_sel`=0, `dn_en`=1), `t2ex_pin` high at the tick counts up and low counts down. Counting down from a count equal to `cap_val` loads 0xFFFF and sets `ovf_flag`.
- R8: In up/down mode, every wrap in either direction toggles `ext_flag`, and `ext_flag` does not drive `irq`. Falling edges of `t2ex_pin` cause neither capture nor reload.
- R9: `irq` is `ovf_flag` OR `ext_flag`, with `ext_flag` masked in up/down mode. Each flag stays set until its clear strobe. A set or toggle in the same cycle as a clear wins.
- R10: In ST_STOP the count, flags and `cap_val` do not change except through writes and clears.
- R11: Reset clears the count, `cap_val` and both flags. `cnt_wr` loads `cnt_din` into the count and `rld_wr` loads `rld_din` into `cap_val` on the next clock, and a write takes priority over a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| t2_pin | input | 1 | Count pin used in counter function |
| t2ex_pin | input | 1 | External pin: capture/reload trigger, or direction in up/down mode |
| ctr_sel | input | 1 | 0 = timer function, 1 = counter function |
| run | input | 1 | Run request for the state machine |
| ext_en | input | 1 | Enables external-pin capture/reload |
| cap_sel | input | 1 | 1 = capture mode, 0 = reload mode |
| dn_en | input | 1 | In reload mode, enables pin-controlled up/down counting |
| cnt_wr | input | 1 | Write strobe for the count |
| cnt_din | input | 16 | Count write data |
| rld_wr | input | 1 | Write strobe for the capture/reload register |
| rld_din | input | 16 | Capture/reload write data |
| ovf_clr | input | 1 | Clears the overflow flag |
| ext_clr | input | 1 | Clears the external flag |
| count | output | 16 | Current count |
| cap_val | output | 16 | Capture/reload register |
| ovf_flag | output | 1 | Overflow/underflow flag |
| ext_flag | output | 1 | External-event flag or seventeenth bit |
| irq | output | 1 | Qualified interrupt request |

## Verification
The bench walks every mode near its wrap points by presetting the count a few steps short of 0xFFFF or of the reload value. A design that compares against the wrong bound, or loads the wrong value, shows a wrong count on exactly one tick. For the capture path it checks that the snapshot holds the pre-increment value; a design off by one here would capture the count already advanced. It sends count-pin pulses that fall between ticks, and holds the pin high for several ticks. A detector that looks at raw edges instead of per-cycle samples would count pulses that should be missed. In up/down mode it makes the external pin fall on a tick and checks that no reload happens. It also checks that the external flag toggles back on the second wrap while `irq` stays low. A design that kept the up-only edge handling, or failed to mask the flag, would reload early or raise `irq`.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        MD_CAPTURE     = 2'd0,
        MD_RELOAD_UP   = 2'd1,
        MD_RELOAD_UPDN = 2'd2
    } tmr_mode_e;

    typedef enum logic {
        ST_STOP = 1'b0,
        ST_RUN  = 1'b1
    } tmr_state_e;

    // Actions requested by the next-count calculator for one tick
    typedef struct packed {
        logic cnt_we;
        logic cap_we;
        logic ovf_set;
        logic ext_set;
        logic ext_tgl;
    } tmr_act_t;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + CW'(1);
        end
    end

    assign tick = (phase_q == LAST);
endmodule

// File: rtl/tmr_fall_det.sv
module tmr_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pin,
    output logic fall
);
    logic smp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_q <= 1'b0;
        end else if (tick) begin
            smp_q <= pin;
        end
    end

    // previous machine-cycle sample high, this one low
    assign fall = tick & smp_q & ~pin;
endmodule

// File: rtl/tmr_next_calc.sv
module tmr_next_calc
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  tmr_mode_e      mode,
    input  logic [W-1:0]   cnt,
    input  logic [W-1:0]   rld,
    input  logic           inc_ev,
    input  logic           ex_fall,
    input  logic           ext_en,
    input  logic           dir_up,
    output logic [W-1:0]   cnt_nxt,
    output tmr_act_t       act
);
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] TOP  = {W{1'b1}};

    always_comb begin
        cnt_nxt = cnt + ONE;
        act     = '0;
        unique case (mode)
            MD_CAPTURE: begin
                if (inc_ev) begin
                    act.cnt_we  = 1'b1;
                    act.ovf_set = (cnt == TOP);
                end
                if (ext_en && ex_fall) begin
                    act.cap_we  = 1'b1;
                    act.ext_set = 1'b1;
                end
            end
            MD_RELOAD_UP: begin
                if (ext_en && ex_fall) begin
                    act.cnt_we  = 1'b1;
                    act.ext_set = 1'b1;
                    cnt_nxt     = rld;
                end else if (inc_ev) begin
                    act.cnt_we = 1'b1;
                    if (cnt == TOP) begin
                        cnt_nxt     = rld;
                        act.ovf_set = 1'b1;
                    end
                end
            end
            MD_RELOAD_UPDN: begin
                if (inc_ev) begin
                    act.cnt_we = 1'b1;
                    if (dir_up) begin
                        if (cnt == TOP) begin
                            cnt_nxt     = rld;
                            act.ovf_set = 1'b1;
                            act.ext_tgl = 1'b1;
                        end
                    end else if (cnt == rld) begin
                        cnt_nxt     = TOP;
                        act.ovf_set = 1'b1;
                        act.ext_tgl = 1'b1;
                    end else begin
                        cnt_nxt = cnt - ONE;
                    end
                end
            end
            default: begin
                cnt_nxt = cnt;
            end
        endcase
    end
endmodule

// File: rtl/cap_tmr.sv
module cap_tmr
    import tmr_pkg::*;
#(
    parameter int W   = 16,
    parameter int DIV = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         t2_pin,
    input  logic         t2ex_pin,
    input  logic         ctr_sel,
    input  logic         run,
    input  logic         ext_en,
    input  logic         cap_sel,
    input  logic         dn_en,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_din,
    input  logic         rld_wr,
    input  logic [W-1:0] rld_din,
    input  logic         ovf_clr,
    input  logic         ext_clr,
    output logic [W-1:0] count,
    output logic [W-1:0] cap_val,
    output logic         ovf_flag,
    output logic         ext_flag,
    output logic         irq
);
    localparam int NPIN = 2;   // index 0: count pin, index 1: external pin

    tmr_state_e state_q;
    tmr_mode_e  mode;
    tmr_act_t   act;
    logic           tick;
    logic [NPIN-1:0] pins;
    logic [NPIN-1:0] falls;
    logic           inc_ev;
    logic           active;
    logic [W-1:0]   cnt_nxt;

    tmr_tick_gen #(.DIV(DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    assign pins = {t2ex_pin, t2_pin};

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        tmr_fall_det u_det (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .pin   (pins[g]),
            .fall  (falls[g])
        );
    end

    always_comb begin
        if (cap_sel)    mode = MD_CAPTURE;
        else if (dn_en) mode = MD_RELOAD_UPDN;
        else            mode = MD_RELOAD_UP;
    end

    assign inc_ev = tick & (ctr_sel ? falls[0] : 1'b1);
    assign active = (state_q == ST_RUN) & tick;

    tmr_next_calc #(.W(W)) u_calc (
        .mode    (mode),
        .cnt     (count),
        .rld     (cap_val),
        .inc_ev  (inc_ev),
        .ex_fall (falls[1]),
        .ext_en  (ext_en),
        .dir_up  (t2ex_pin),
        .cnt_nxt (cnt_nxt),
        .act     (act)
    );

    // run state machine: start / halt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_STOP;
        end else begin
            unique case (state_q)
                ST_STOP: if (run)  state_q <= ST_RUN;
                ST_RUN:  if (!run) state_q <= ST_STOP;
                default: state_q <= ST_STOP;
            endcase
        end
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count    <= '0;
            cap_val  <= '0;
            ovf_flag <= 1'b0;
            ext_flag <= 1'b0;
        end else begin
            if (cnt_wr)                    count <= cnt_din;
            else if (active && act.cnt_we) count <= cnt_nxt;

            if (rld_wr)                    cap_val <= rld_din;
            else if (active && act.cap_we) cap_val <= count;

            if (active && act.ovf_set)     ovf_flag <= 1'b1;
            else if (ovf_clr)              ovf_flag <= 1'b0;

            if (active && act.ext_tgl)     ext_flag <= ~ext_flag;
            else if (active && act.ext_set) ext_flag <= 1'b1;
            else if (ext_clr)              ext_flag <= 1'b0;
        end
    end

    assign irq = ovf_flag | (ext_flag & (mode != MD_RELOAD_UPDN));
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         run,
    input logic         cnt_wr,
    input logic         rld_wr,
    input logic         cap_sel,
    input logic         dn_en,
    input logic         ovf_clr,
    input logic         ext_clr,
    input logic [W-1:0] count,
    input logic [W-1:0] cap_val,
    input logic         ovf_flag,
    input logic         ext_flag,
    input logic         irq
);
    AST_STOP_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) ##1 !cnt_wr |=> $stable(count)); // R10

    AST_RELOAD_REG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!rld_wr && !cap_sel) |=> $stable(cap_val)); // R5

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag); // R9

    AST_EXT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_flag && !ext_clr && (cap_sel || !dn_en)) |=> ext_flag); // R9

    AST_UPDN_NO_EXT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_sel && dn_en && !ovf_flag) |-> !irq); // R8
endmodule

bind cap_tmr tmr_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .cnt_wr   (cnt_wr),
    .rld_wr   (rld_wr),
    .cap_sel  (cap_sel),
    .dn_en    (dn_en),
    .ovf_clr  (ovf_clr),
    .ext_clr  (ext_clr),
    .count    (count),
    .cap_val  (cap_val),
    .ovf_flag (ovf_flag),
    .ext_flag (ext_flag),
    .irq      (irq)
);

// File: tb/tb_cap_tmr.sv
module tb_cap_tmr;
    localparam int W   = 16;
    localparam int DIV = 12;

    logic clk = 1'b0;
    logic rst_n;
    logic t2_pin, t2ex_pin, ctr_sel, run, ext_en, cap_sel, dn_en;
    logic cnt_wr, rld_wr, ovf_clr, ext_clr;
    logic [W-1:0] cnt_din, rld_din;
    logic [W-1:0] count, cap_val;
    logic ovf_flag, ext_flag, irq;

    int checks = 0;
    int errors = 0;
    int phase  = 0;

    always #5 clk = ~clk;

    cap_tmr #(.W(W), .DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .t2_pin(t2_pin), .t2ex_pin(t2ex_pin),
        .ctr_sel(ctr_sel), .run(run), .ext_en(ext_en), .cap_sel(cap_sel),
        .dn_en(dn_en), .cnt_wr(cnt_wr), .cnt_din(cnt_din), .rld_wr(rld_wr),
        .rld_din(rld_din), .ovf_clr(ovf_clr), .ext_clr(ext_clr),
        .count(count), .cap_val(cap_val), .ovf_flag(ovf_flag),
        .ext_flag(ext_flag), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic nxt();
        @(negedge clk);
        phase = (phase == DIV - 1) ? 0 : phase + 1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            nxt();
            while (phase != 0) nxt();
        end
    endtask

    task automatic wr_cnt(input logic [W-1:0] v);
        cnt_wr = 1'b1; cnt_din = v; nxt(); cnt_wr = 1'b0;
    endtask

    task automatic wr_rld(input logic [W-1:0] v);
        rld_wr = 1'b1; rld_din = v; nxt(); rld_wr = 1'b0;
    endtask

    task automatic clr_ovf();
        ovf_clr = 1'b1; nxt(); ovf_clr = 1'b0;
    endtask

    task automatic clr_ext();
        ext_clr = 1'b1; nxt(); ext_clr = 1'b0;
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] base;
        rst_n = 1'b0; t2_pin = 1'b0; t2ex_pin = 1'b1; ctr_sel = 1'b0;
        run = 1'b0; ext_en = 1'b0; cap_sel = 1'b1; dn_en = 1'b0;
        cnt_wr = 1'b0; rld_wr = 1'b0; ovf_clr = 1'b0; ext_clr = 1'b0;
        cnt_din = '0; rld_din = '0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 count", count, 0);
        chk("R11 cap_val", cap_val, 0);
        chk("R11 flags", {ovf_flag, ext_flag, irq}, 0);
        rst_n = 1'b1;
        repeat (30) @(negedge clk);
        chk("R10 stopped", count, 0);

        // start and align to the machine cycle
        run = 1'b1;
        for (int i = 0; i < 40 && count == 0; i++) @(negedge clk);
        phase = 0;
        chk("R1 first step", count, 1);

        // R1 one step per 12 clocks, steady mid-cycle
        for (int k = 1; k <= 8; k++) begin
            repeat (6) nxt();
            chk("R1 steady", count, 16'(k));
            ticks(1);
            chk("R1 step", count, 16'(k + 1));
        end

        // R10 halt freezes the count
        run = 1'b0;
        base = count;
        ticks(3);
        chk("R10 halted", count, base);
        run = 1'b1;
        ticks(1);
        chk("R10 resumed", count, base + 1);

        // R3 capture-mode wrap sweep
        for (int d = 1; d <= 3; d++) begin
            wr_cnt(16'hFFFF - 16'(d));
            chk("R11 write", count, 16'hFFFF - 16'(d));
            ticks(d);
            chk("R3 top", {ovf_flag, count}, {1'b0, 16'hFFFF});
            ticks(1);
            chk("R3 wrap", {irq, ovf_flag, count}, {2'b11, 16'h0000});
            ticks(1);
            chk("R9 sticky", ovf_flag, 1);
            clr_ovf();
            chk("R9 clear", {ovf_flag, irq}, 0);
        end

        // R4 capture of pre-increment count
        ext_en = 1'b1;
        for (int i = 0; i < 4; i++) begin
            base = 16'h0100 + 16'(i * 16'h0111);
            wr_cnt(base);
            t2ex_pin = 1'b0;
            ticks(1);
            chk("R4 capture", cap_val, base);
            chk("R4 count", count, base + 1);
            chk("R4 flag", {ext_flag, irq}, 2'b11);
            t2ex_pin = 1'b1;
            ticks(1);
            clr_ext();
        end
        ext_en = 1'b0;
        base = cap_val;
        t2ex_pin = 1'b0;
        ticks(1);
        chk("R4 disabled cap", cap_val, base);
        chk("R4 disabled flag", ext_flag, 0);
        t2ex_pin = 1'b1;
        ticks(1);

        // R2 counter function
        ctr_sel = 1'b1;
        wr_cnt(16'h0010);
        for (int n = 1; n <= 5; n++) begin
            t2_pin = 1'b1; ticks(1);
            t2_pin = 1'b0; ticks(1);
            chk("R2 pulse", count, 16'h0010 + 16'(n));
        end
        nxt(); t2_pin = 1'b1; repeat (4) nxt(); t2_pin = 1'b0;
        ticks(2);
        chk("R2 unsampled pulse", count, 16'h0015);
        t2_pin = 1'b1; ticks(3);
        chk("R2 held high", count, 16'h0015);
        t2_pin = 1'b0; ticks(1);
        chk("R2 release", count, 16'h0016);
        ctr_sel = 1'b0;

        // R5 up-only reload sweep
        cap_sel = 1'b0;
        for (int i = 0; i < 3; i++) begin
            base = (i == 0) ? 16'h1234 : (i == 1) ? 16'hFF00 : 16'h0000;
            wr_rld(base);
            chk("R11 reload write", cap_val, base);
            wr_cnt(16'hFFFE);
            ticks(1);
            chk("R5 top", count, 16'hFFFF);
            ticks(1);
            chk("R5 reload", {ovf_flag, count}, {1'b1, base});
            clr_ovf();
            ticks(1);
            chk("R5 after", count, base + 1);
        end

        // R6 external forced reload
        ext_en = 1'b1;
        wr_rld(16'h4000);
        wr_cnt(16'h0050);
        t2ex_pin = 1'b0;
        ticks(1);
        chk("R6 forced reload", {ovf_flag, ext_flag, count}, {2'b01, 16'h4000});
        t2ex_pin = 1'b1;
        ticks(1);
        clr_ext();

        // R7 / R8 up/down mode, external enable left on
        dn_en = 1'b1;
        wr_rld(16'h2000);
        wr_cnt(16'h2002);
        t2ex_pin = 1'b0;
        ticks(1);
        chk("R8 fall ignored", {ext_flag, count}, {1'b0, 16'h2001});
        ticks(1);
        chk("R7 down", count, 16'h2000);
        ticks(1);
        chk("R7 underflow", {ovf_flag, ext_flag, count}, {2'b11, 16'hFFFF});
        chk("R9 irq ovf", irq, 1);
        clr_ovf();
        chk("R8 ext masked", {ext_flag, irq}, 2'b10);
        ticks(1);
        chk("R7 down2", count, 16'hFFFE);
        t2ex_pin = 1'b1;
        ticks(1);
        chk("R7 up", count, 16'hFFFF);
        ticks(1);
        chk("R8 toggle back", {ovf_flag, ext_flag, count}, {2'b10, 16'h2000});
        chk("R8 cap kept", cap_val, 16'h2000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule